// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the bus-facing half of an I2C controller that runs in master mode only. Software, through a control register held elsewhere, drives four bits into it: an enable, a start/hold bit, a transmit-mode bit and an acknowledge-control bit. It also supplies the current contents of the data register and a one-cycle write strobe. The engine turns these into START, byte, acknowledge and STOP sequences on open-drain SCL and SDA. Each line is either pulled low or released, and external pull-ups supply the high level.

A transfer opens when the start bit rises while the engine is enabled. The engine captures the data register as the header byte and sends it after START. The header holds a 7-bit address and a direction bit in bit 0, where 1 means read and 0 means write. After each nine-clock byte the engine pulses a one-cycle completion flag. In transmit mode it then holds SCL low until software writes the next byte. In receive mode it goes straight on to clock in the next byte. It answers each received byte with ACK or NACK, as the acknowledge-control bit selects. Clearing the start bit makes the engine issue STOP once the byte in flight is complete.

The engine reports bus-busy, the acknowledge it received and an arbitration-lost flag. SCL runs at a fixed divide `DIV` of the system clock, made of four quarters of `DIV/4` cycles each.

Top module: `i2cm_engine`

## Requirements
- R1: After reset both line drivers are released, and busy, done, rx_ack, arb_lost and rx_byte are all 0.
- R2: When start rises (0 to 1) while enable is 1 and the engine is idle, busy is 1 from the next cycle and arb_lost reads 0. The START condition then takes DIV cycles: SDA is pulled low in the third quarter while SCL stays released.
- R3: The header byte is taken from dat_in at START and is always transmitted, MSB first. Each bit takes DIV cycles: SCL is pulled low in quarters 1 and 4 and released in quarters 2 and 3. SDA is sampled at the end of quarter 2.
- R4: SDA changes only while SCL is pulled low, except for one fall at START and one rise at STOP. A complete transfer therefore shows exactly two SDA changes while SCL is high.
- R5: done is a one-cycle pulse at the end of the ninth clock of each byte. For the header it is seen 1 + 10*DIV clock edges after the edge that accepts the start.
- R6: For every transmitted byte, rx_ack takes the SDA level sampled in the ninth (acknowledge) clock: 0 means ACK and 1 means NACK.
- R7: In transmit mode, after done the engine holds SCL low and waits. A dat_wr pulse loads dat_in and sends it, and its done is seen 1 + 9*DIV edges after the edge that takes the strobe.
- R8: In receive mode (tx_mode 0), bytes are shifted in MSB first with no gap. rx_byte updates with done, 9*DIV cycles after the previous done. In the ninth clock the engine pulls SDA low if ack_ctl was 0 at the end of bit 8, and otherwise leaves it released (NACK).
- R9: If start is 0 at the end of a byte, the engine issues STOP. It pulls SCL and SDA low, releases SCL, then releases SDA while SCL is high. busy falls DIV cycles after that byte's done.
- R10: If the engine releases SDA to send a 1 but samples SDA low, it sets arb_lost, releases both lines and returns to idle. arb_lost clears at the next START.
- R11: When enable is 0, both lines are released and busy is 0 from the next cycle, whatever state the engine was in.
- R12: A rise of start while enable is 0 starts nothing, and enabling later while start is already 1 does not start a transfer either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Engine enable |
| sta | input | 1 | Start/hold bit: a rise opens a transfer, 0 closes it with STOP |
| tx_mode | input | 1 | 1 = transmit bytes after the header, 0 = receive |
| ack_ctl | input | 1 | 0 = ACK received bytes, 1 = NACK |
| dat_in | input | 8 | Data register contents (header or next transmit byte) |
| dat_wr | input | 1 | One-cycle data register write strobe |
| sda_i | input | 1 | Level of the SDA line as seen on the pad |
| scl_drv_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drv_low | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_byte | output | 8 | Last received byte |
| done | output | 1 | One-cycle byte-complete pulse |
| busy | output | 1 | Bus busy from START until STOP completes |
| rx_ack | output | 1 | Acknowledge level received for the last transmitted byte |
| arb_lost | output | 1 | Arbitration lost |

## Verification
Every result has a fixed cycle distance from its stimulus. busy is due one edge after the start is accepted. The header's done pulse is due 1 + 10*DIV edges after the start is set, a written byte's done 1 + 9*DIV edges after the strobe, a received follow-on byte's done 9*DIV edges after the previous done, and the fall of busy DIV edges after the last done. The bench drives inputs on the falling clock edge and counts rising edges until each output appears, then compares that count with these formulas. Line-level results are checked through a slave model that listens on the resolved lines. These results are the captured header and data, the master's acknowledge level and the STOP condition.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C master byte engine.
// Assumes a bit cell of four equal quarters; quarter codes are fixed by the
// line-drive table in the top module.
package i2cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_BITS  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_STOP  = 3'd4
    } i2cm_state_t;

    localparam logic [1:0] Q_LOW_A = 2'd0;  // SCL low, SDA may change
    localparam logic [1:0] Q_RISE  = 2'd1;  // SCL released, sample at its end
    localparam logic [1:0] Q_HIGH  = 2'd2;  // SCL released
    localparam logic [1:0] Q_LOW_B = 2'd3;  // SCL low again

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2cm_qtimer.sv
// Quarter-cell timer: divides the system clock into quarters of QTR cycles
// and counts quarters 0..3 while run is high.
// Assumes run is held high for whole cells; dropping run clears the phase.
module i2cm_qtimer #(
    parameter int QTR = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [1:0] q,
    output logic       tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Advance the cycle count and the quarter index; idle clears both.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            q   <= 2'd0;
        end else if (tick) begin
            cnt <= '0;
            q   <= q + 2'd1;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/i2cm_shreg.sv
// Byte shift register: parallel load, shift-in of a sampled bit, or left
// shift to present the next transmit bit on the MSB.
// Assumes at most one of the three controls matters per cycle (load wins).
module i2cm_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         cap,
    input  logic         din,
    input  logic         shl,
    output logic [W-1:0] q
);
    // Load, capture or shift the byte being moved across the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= ld_val;
        end else if (cap) begin
            q <= {q[W-2:0], din};
        end else if (shl) begin
            q <= {q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/i2cm_engine.sv
// I2C master byte engine. Control bits from a register file start a
// transfer (header from dat_in), move bytes in either direction, pick
// ACK/NACK for received bytes and close with STOP. Lines are open drain:
// outputs only request a pull-low.
// Assumes DIV is a multiple of 4 and at least 4; slaves never stretch SCL.
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sta,
    input  logic       tx_mode,
    input  logic       ack_ctl,
    input  logic [7:0] dat_in,
    input  logic       dat_wr,
    input  logic       sda_i,
    output logic       scl_drv_low,
    output logic       sda_drv_low,
    output logic [7:0] rx_byte,
    output logic       done,
    output logic       busy,
    output logic       rx_ack,
    output logic       arb_lost
);
    localparam int QTR = DIV / 4;
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);
    localparam logic [3:0] LAST_DATA = 4'(BYTE_BITS - 1);

    i2cm_state_t st;
    logic [3:0]  bitn;
    logic        is_tx;
    logic        ack_hold;
    logic        sta_q;
    logic        run;
    logic [1:0]  q;
    logic        tick;
    logic        sample;
    logic        bit_end;
    logic        start_req;
    logic        in_data;
    logic [7:0]  sh_q;
    logic        sh_load;
    logic        sh_cap;
    logic        sh_shl;

    assign run       = (st == ST_START) || (st == ST_BITS) || (st == ST_STOP);
    assign sample    = tick && (q == Q_RISE);
    assign bit_end   = tick && (q == Q_LOW_B);
    assign start_req = en && sta && !sta_q;
    assign in_data   = (bitn < ACK_SLOT);
    assign busy      = (st != ST_IDLE);

    assign sh_load = (st == ST_IDLE && start_req) ||
                     (st == ST_HOLD && sta && tx_mode && dat_wr);
    assign sh_cap  = (st == ST_BITS) && !is_tx && in_data && sample;
    assign sh_shl  = (st == ST_BITS) && is_tx && in_data && bit_end;

    i2cm_qtimer #(.QTR(QTR)) i_qtimer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .q    (q),
        .tick (tick)
    );

    i2cm_shreg #(.W(8)) i_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .ld_val(dat_in),
        .cap   (sh_cap),
        .din   (sda_i),
        .shl   (sh_shl),
        .q     (sh_q)
    );

    // Sequence START, byte cells, hold, STOP; latch status at fixed points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bitn     <= 4'd0;
            is_tx    <= 1'b0;
            ack_hold <= 1'b0;
            sta_q    <= 1'b0;
            done     <= 1'b0;
            rx_byte  <= 8'd0;
            rx_ack   <= 1'b0;
            arb_lost <= 1'b0;
        end else begin
            sta_q <= sta;
            done  <= 1'b0;
            if (!en) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (start_req) begin
                            st       <= ST_START;
                            arb_lost <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (bit_end) begin
                            st    <= ST_BITS;
                            bitn  <= 4'd0;
                            is_tx <= 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (sample) begin
                            if (is_tx && in_data && sh_q[7] && !sda_i) begin
                                arb_lost <= 1'b1;
                                st       <= ST_IDLE;
                            end
                            if (is_tx && !in_data) begin
                                rx_ack <= sda_i;
                            end
                        end
                        if (bit_end) begin
                            if (bitn == LAST_DATA) begin
                                ack_hold <= ack_ctl;
                            end
                            if (!in_data) begin
                                done <= 1'b1;
                                bitn <= 4'd0;
                                if (!is_tx) begin
                                    rx_byte <= sh_q;
                                end
                                if (!sta) begin
                                    st <= ST_STOP;
                                end else if (tx_mode) begin
                                    st <= ST_HOLD;
                                end else begin
                                    is_tx <= 1'b0;
                                end
                            end else begin
                                bitn <= bitn + 4'd1;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (!sta) begin
                            st <= ST_STOP;
                        end else if (!tx_mode) begin
                            st    <= ST_BITS;
                            is_tx <= 1'b0;
                            bitn  <= 4'd0;
                        end else if (dat_wr) begin
                            st    <= ST_BITS;
                            is_tx <= 1'b1;
                            bitn  <= 4'd0;
                        end
                    end
                    ST_STOP: begin
                        if (bit_end) begin
                            st <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Map state and quarter to the two open-drain pull-low requests.
    always_comb begin
        scl_drv_low = 1'b0;
        sda_drv_low = 1'b0;
        case (st)
            ST_START: begin
                sda_drv_low = q[1];
            end
            ST_BITS: begin
                scl_drv_low = (q == Q_LOW_A) || (q == Q_LOW_B);
                if (in_data) begin
                    sda_drv_low = is_tx && !sh_q[7];
                end else begin
                    sda_drv_low = !is_tx && !ack_hold;
                end
            end
            ST_HOLD: begin
                scl_drv_low = 1'b1;
            end
            ST_STOP: begin
                scl_drv_low = (q == Q_LOW_A);
                sda_drv_low = (q != Q_LOW_B);
            end
            default: begin
                scl_drv_low = 1'b0;
                sda_drv_low = 1'b0;
            end
        endcase
    end

    AST_SDA_STILL_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BITS && $past(st) == ST_BITS && !scl_drv_low && !$past(scl_drv_low))
            |-> $stable(sda_drv_low)); // R4

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_drv_low && !sda_drv_low && !busy)); // R11

    AST_ARB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!scl_drv_low && !sda_drv_low && !busy)); // R10

    AST_START_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drv_low) && !scl_drv_low) |-> busy); // R2

    AST_RX_BYTE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_byte)); // R8

endmodule

// File: tb/test_i2cm_engine.sv
`timescale 1ns/1ps
module test_i2cm_engine;
    localparam int DIV = 8;
    localparam logic [6:0] SLV_ADDR = 7'h50;
    localparam int NVEC = 6;
    // {header, data, expected acknowledge from slave}
    localparam logic [16:0] VEC [0:NVEC-1] = '{
        {8'hA0, 8'h3C, 1'b0},
        {8'hA0, 8'h81, 1'b0},
        {8'hA2, 8'h55, 1'b1},
        {8'hA1, 8'hC5, 1'b0},
        {8'hA1, 8'h0F, 1'b0},
        {8'hA3, 8'h6A, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sta = 1'b0;
    logic       tx_mode = 1'b0;
    logic       ack_ctl = 1'b0;
    logic [7:0] dat_in = 8'd0;
    logic       dat_wr = 1'b0;
    logic       jam = 1'b0;
    logic       scl_drv_low;
    logic       sda_drv_low;
    logic [7:0] rx_byte;
    logic       done;
    logic       busy;
    logic       rx_ack;
    logic       arb_lost;
    logic       slv_low;
    logic       scl_ln;
    logic       sda_ln;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    assign scl_ln = !scl_drv_low;
    assign sda_ln = !(sda_drv_low || slv_low || jam);

    i2cm_engine #(.DIV(DIV)) i_i2cm_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sta        (sta),
        .tx_mode    (tx_mode),
        .ack_ctl    (ack_ctl),
        .dat_in     (dat_in),
        .dat_wr     (dat_wr),
        .sda_i      (sda_ln),
        .scl_drv_low(scl_drv_low),
        .sda_drv_low(sda_drv_low),
        .rx_byte    (rx_byte),
        .done       (done),
        .busy       (busy),
        .rx_ack     (rx_ack),
        .arb_lost   (arb_lost)
    );

    always #2.5 clk = ~clk;

    // Slave model on the resolved lines, plus a count of SDA moves under high SCL.
    logic       pscl, psda, act, sel, rd, hdrf, mack, stop_seen;
    logic [7:0] sh, got, hdr_got, rdat, shr;
    int         bc;
    logic       p_scl_drv, p_sda_drv;
    int         hi_changes;

    initial begin
        slv_low = 1'b0; pscl = 1'b1; psda = 1'b1; act = 1'b0; sel = 1'b0;
        rd = 1'b0; hdrf = 1'b0; mack = 1'b0; stop_seen = 1'b0;
        sh = 8'd0; got = 8'd0; hdr_got = 8'd0; rdat = 8'd0; shr = 8'd0;
        bc = 0; p_scl_drv = 1'b0; p_sda_drv = 1'b0; hi_changes = 0;
    end

    always @(negedge clk) begin
        if (!scl_drv_low && !p_scl_drv && (sda_drv_low != p_sda_drv))
            hi_changes = hi_changes + 1;
        p_scl_drv = scl_drv_low;
        p_sda_drv = sda_drv_low;

        if (scl_ln && pscl && psda && !sda_ln) begin
            act = 1'b1; hdrf = 1'b1; sel = 1'b0; bc = 0; slv_low = 1'b0;
        end else if (scl_ln && pscl && !psda && sda_ln) begin
            act = 1'b0; stop_seen = 1'b1; slv_low = 1'b0;
        end else if (act && scl_ln && !pscl) begin
            if (bc < 8) sh = {sh[6:0], sda_ln};
            else mack = sda_ln;
            bc = bc + 1;
        end else if (act && !scl_ln && pscl) begin
            if (bc == 8) begin
                if (hdrf) begin
                    hdr_got = sh;
                    sel = (sh[7:1] == SLV_ADDR);
                    rd = sh[0];
                    slv_low = sel;
                end else if (sel && !rd) begin
                    got = sh;
                    slv_low = 1'b1;
                end else begin
                    slv_low = 1'b0;
                end
            end else if (bc == 9) begin
                bc = 0;
                if (sel && rd && !mack) begin
                    shr = rdat;
                    slv_low = !rdat[7];
                end else begin
                    slv_low = 1'b0;
                end
                hdrf = 1'b0;
            end else if (bc >= 1 && bc <= 7 && sel && rd && !hdrf) begin
                slv_low = !shr[7 - bc];
            end
        end
        pscl = scl_ln;
        psda = sda_ln;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // Wait for done, counting falling edges; n carries the count in and out.
    task automatic wait_done(inout int n);
        while (!done) begin
            @(negedge clk);
            n = n + 1;
        end
    endtask

    task automatic do_xfer(input logic [7:0] hdr, input logic [7:0] dat, input logic exp_ack);
        int n;
        @(negedge clk);
        hi_changes = 0;
        stop_seen = 1'b0;
        dat_in = hdr; tx_mode = !hdr[0]; ack_ctl = hdr[0]; rdat = dat; sta = 1'b1;
        @(negedge clk);
        chk(busy && !arb_lost, "R2 busy set, arb clear after START", {busy, arb_lost}, 2'b10);
        n = 1;
        wait_done(n);
        chk(n == 1 + 10 * DIV, "R5 header done latency", n, 1 + 10 * DIV);
        chk(rx_ack == exp_ack, "R6 header acknowledge", rx_ack, exp_ack);
        chk(hdr_got == hdr, "R3 header on the bus", hdr_got, hdr);
        if (!hdr[0]) begin
            repeat (12) @(negedge clk);
            chk(scl_drv_low && busy && !done, "R7 SCL held low awaiting byte",
                {scl_drv_low, busy, done}, 3'b110);
            dat_in = dat; dat_wr = 1'b1;
            @(negedge clk);
            dat_wr = 1'b0;
            n = 1;
            repeat (10) begin @(negedge clk); n = n + 1; end
            sta = 1'b0;
            wait_done(n);
            chk(n == 1 + 9 * DIV, "R7 written byte done latency", n, 1 + 9 * DIV);
            chk(rx_ack == exp_ack, "R6 data acknowledge", rx_ack, exp_ack);
            if (!exp_ack) chk(got == dat, "R3 data byte on the bus", got, dat);
        end else begin
            n = 0;
            repeat (10) begin @(negedge clk); n = n + 1; end
            sta = 1'b0;
            wait_done(n);
            chk(n == 9 * DIV, "R8 received byte done latency", n, 9 * DIV);
            chk(rx_byte == (exp_ack ? 8'hFF : dat), "R8 received byte", rx_byte,
                exp_ack ? 8'hFF : dat);
            if (!exp_ack) chk(mack == 1'b1, "R8 NACK sent on last byte", mack, 1);
        end
        n = 0;
        while (busy) begin @(negedge clk); n = n + 1; end
        chk(n == DIV, "R9 busy falls after STOP", n, DIV);
        chk(stop_seen, "R9 STOP seen on the bus", stop_seen, 1);
        chk(hi_changes == 2, "R4 SDA moves under high SCL", hi_changes, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!scl_drv_low && !sda_drv_low && !busy && !done && !rx_ack && !arb_lost &&
            rx_byte == 8'd0, "R1 reset state",
            {scl_drv_low, sda_drv_low, busy, done, rx_ack, arb_lost, rx_byte}, 0);

        // R12: start edge while disabled, then enabling with start held
        sta = 1'b1;
        repeat (20) @(negedge clk);
        chk(!busy && !scl_drv_low && !sda_drv_low, "R12 no start while disabled",
            {busy, scl_drv_low, sda_drv_low}, 0);
        en = 1'b1;
        repeat (20) @(negedge clk);
        chk(!busy, "R12 no start on enable with start held", busy, 0);
        sta = 1'b0;
        repeat (3) @(negedge clk);

        // R10: SDA forced low while the engine sends a 1
        dat_in = 8'hA0; tx_mode = 1'b1; jam = 1'b1; sta = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(arb_lost && !busy && !scl_drv_low && !sda_drv_low && !seen,
            "R10 arbitration lost releases bus",
            {arb_lost, busy, scl_drv_low, sda_drv_low, seen}, 5'b10000);
        jam = 1'b0; sta = 1'b0;
        repeat (4) @(negedge clk);
        chk(arb_lost, "R10 flag holds until next START", arb_lost, 1);

        // Vector table walk: writes and reads, matched and unmatched addresses
        for (int v = 0; v < NVEC; v++) begin
            do_xfer(VEC[v][16:9], VEC[v][8:1], VEC[v][0]);
            repeat (5) @(negedge clk);
        end

        // R8: two-byte read, ACK on the first byte, NACK on the second
        dat_in = 8'hA1; tx_mode = 1'b0; ack_ctl = 1'b0; rdat = 8'h96; sta = 1'b1;
        n = 0;
        wait_done(n);
        repeat (2) @(negedge clk);
        wait_done(n);
        chk(rx_byte == 8'h96 && mack == 1'b0, "R8 first byte acknowledged",
            {rx_byte, mack}, {8'h96, 1'b0});
        ack_ctl = 1'b1;
        n = 0;
        repeat (5) begin @(negedge clk); n = n + 1; end
        sta = 1'b0;
        wait_done(n);
        chk(n == 9 * DIV, "R8 back-to-back byte spacing", n, 9 * DIV);
        chk(rx_byte == 8'h96 && mack == 1'b1, "R8 last byte not acknowledged",
            {rx_byte, mack}, {8'h96, 1'b1});
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);

        // R11: disable in mid-header
        dat_in = 8'hA0; tx_mode = 1'b1; sta = 1'b1;
        repeat (30) @(negedge clk);
        chk(busy, "R11 transfer under way before disable", busy, 1);
        en = 1'b0;
        @(negedge clk);
        chk(!busy && !scl_drv_low && !sda_drv_low, "R11 disable releases at once",
            {busy, scl_drv_low, sda_drv_low}, 0);
        repeat (10) @(negedge clk);
        chk(!busy && !scl_drv_low && !sda_drv_low, "R11 stays released",
            {busy, scl_drv_low, sda_drv_low}, 0);
        sta = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule